// File: doc/BRIEF.md
# Single-Edge PWM Timer

This block is a 16-bit up-counter with one cycle-length register and three output channels. The counter moves forward by one on each clock-enable tick. On the tick after it equals the cycle length it goes back to zero, which starts a new PWM cycle. Each channel has its own match register and a mode bit. In PWM mode the channel output is held low at the start of each cycle and rises on the tick where the counter reaches the channel's match value. In software mode the output shows a stored software output bit.

Software sets up the block through a single-cycle register write port. The registers are:

- the cycle length,
- one match value per channel,
- a mode field,
- a software output field.

A write takes effect on the clock edge where it is presented. There is no shadow copy. The counter value is available as an output next to the three pins.

Top module: `pwm_timer`

## Requirements
- R1: After reset the count is 0, all three pins are 0, every channel is in software mode with its software output bit at 0, and the cycle length is 16'hFFFF.
- R2: The count changes only on a clock edge where tick_i is 1. On such an edge it increases by one, unless R3 applies. On all other edges it holds.
- R3: On a tick where the count equals the cycle length (address 0, bits 15:0), the count becomes 0, which starts a new cycle.
- R4: Bit k of the mode register (address 4, bits 2:0) selects PWM mode (1) or software mode (0) for pin k. In software mode, pin k shows bit k of the software output register (address 5, bits 2:0) from the edge of the write onward.
- R5: On the tick that starts a cycle, a PWM output with a nonzero match value goes to 0.
- R6: A PWM output goes to 1 on the tick where the count becomes equal to its match value (channel k at address k+1, bits 15:0). It stays at 1 until the next cycle start.
- R7: A match value above the cycle length keeps the PWM output at 0. If such a value is written while the output is 1, the output stays at 1 until the next cycle start and then goes to 0.
- R8: A match value equal to the cycle length gives a high pulse one tick wide, once per cycle.
- R9: A match value of 0 drives the PWM output to 1 at the first cycle start. The output then stays at 1.
- R10: Bits 31:3 of a write to the mode register have no effect, and a match-register write acts on the next tick with no delay.
- R11: A software output write to a channel in PWM mode leaves its pin unchanged. The stored value appears on the pin once that channel returns to software mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Clock enable for counting |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address (0 cycle length, 1..3 channel match, 4 mode, 5 software output) |
| wr_data_i | input | 32 | Register write data |
| mat_o | output | 3 | Channel output pins |
| count_o | output | 16 | Current counter value |

## Verification
The hardest case to reach is a match value raised above the cycle length while the output is already high (R7). The bench first lets channel 3 rise on a small match value partway through a cycle. It then rewrites that match to a value beyond the cycle length, and the pin must stay high until the wrap and then stay low for whole cycles. A second hard case is the match-equals-length pulse (R8) combined with gaps in the tick stream. The bench runs part of the sequence with a sparse tick pattern, so that both the pulse width and the wrap are judged in ticks and not in clock cycles.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned ADDR_CYCLE = 0;

  function automatic int unsigned addr_match(input int unsigned ch);
    return ch + 1;
  endfunction

  function automatic int unsigned addr_mode(input int unsigned n_ch);
    return n_ch + 1;
  endfunction

  function automatic int unsigned addr_swout(input int unsigned n_ch);
    return n_ch + 2;
  endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned N_CH   = 3,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           wr_addr_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  output logic [CNT_W-1:0]            cyc_len_o,
  output logic [N_CH-1:0][CNT_W-1:0]  match_o,
  output logic [N_CH-1:0]             mode_o,
  output logic [N_CH-1:0]             swout_o
);
  localparam logic [ADDR_W-1:0] A_CYC   = ADDR_W'(pwm_pkg::ADDR_CYCLE);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(pwm_pkg::addr_mode(N_CH));
  localparam logic [ADDR_W-1:0] A_SWOUT = ADDR_W'(pwm_pkg::addr_swout(N_CH));

  logic unused_hi;
  assign unused_hi = ^wr_data_i[DATA_W-1:CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cyc_len_o <= '1;
    else if (wr_en_i && wr_addr_i == A_CYC) cyc_len_o <= wr_data_i[CNT_W-1:0];
  end

  // mode/swout keep only the low N_CH bits of the data word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o  <= '0;
      swout_o <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_MODE)  mode_o  <= wr_data_i[N_CH-1:0];
      if (wr_addr_i == A_SWOUT) swout_o <= wr_data_i[N_CH-1:0];
    end
  end

  for (genvar k = 0; k < N_CH; k++) begin : g_match
    localparam logic [ADDR_W-1:0] A_M = ADDR_W'(pwm_pkg::addr_match(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          match_o[k] <= '0;
      else if (wr_en_i && wr_addr_i == A_M) match_o[k] <= wr_data_i[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cyc_len_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] next_o,
  output logic             start_o
);
  // wrap on cycle length; natural overflow also lands on zero
  assign next_o  = (count_o == cyc_len_i) ? '0 : count_o + CNT_W'(1);
  assign start_o = (next_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_o <= '0;
    else if (tick_i) count_o <= next_o;
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] next_i,
  input  logic [CNT_W-1:0] match_i,
  input  logic             mode_i,
  input  logic             swout_i,
  output logic             pin_o
);
  logic pwm_q;

  // PWM state keeps running in software mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else if (tick_i) begin
      if (start_i)                pwm_q <= (match_i == '0);
      else if (next_i == match_i) pwm_q <= 1'b1;
    end
  end

  assign pin_o = mode_i ? pwm_q : swout_i;
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned N_CH   = 3,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = $clog2(N_CH + 3)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [N_CH-1:0]   mat_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [CNT_W-1:0]           cyc_len;
  logic [N_CH-1:0][CNT_W-1:0] match;
  logic [N_CH-1:0]            mode;
  logic [N_CH-1:0]            swout;
  logic [CNT_W-1:0]           cnt_next;
  logic                       cyc_start;

  pwm_regs #(.CNT_W(CNT_W), .N_CH(N_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .cyc_len_o (cyc_len),
    .match_o   (match),
    .mode_o    (mode),
    .swout_o   (swout)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .cyc_len_i (cyc_len),
    .count_o   (count_o),
    .next_o    (cnt_next),
    .start_o   (cyc_start)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .start_i (cyc_start),
      .next_i  (cnt_next),
      .match_i (match[k]),
      .mode_i  (mode[k]),
      .swout_i (swout[k]),
      .pin_o   (mat_o[k])
    );
  end
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_CH  = 3
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       tick_i,
  input logic                       wr_en_i,
  input logic [CNT_W-1:0]           count_o,
  input logic [N_CH-1:0]            mat_o,
  input logic [CNT_W-1:0]           cyc_len_i,
  input logic [N_CH-1:0][CNT_W-1:0] match_i,
  input logic [N_CH-1:0]            mode_i
);
  a_r2_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(count_o));

  a_r2_step_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && count_o != cyc_len_i) |=> count_o == CNT_W'($past(count_o) + CNT_W'(1)));

  a_r3_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && count_o == cyc_len_i) |=> count_o == '0);

  for (genvar k = 0; k < N_CH; k++) begin : g_chk
    a_r6_rise_only_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(mat_o[k]) && mode_i[k] && $past(mode_i[k]) && !$past(wr_en_i))
        |-> (count_o == match_i[k] || count_o == '0));

    a_r5_low_at_cycle_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(tick_i && !wr_en_i && mode_i[k]) && mode_i[k] && count_o == '0
        && match_i[k] != '0) |-> !mat_o[k]);

    a_r9_zero_match_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(tick_i && !wr_en_i && mode_i[k]) && mode_i[k] && count_o == '0
        && match_i[k] == '0) |-> mat_o[k]);
  end
endmodule

bind pwm_timer pwm_timer_chk #(.CNT_W(CNT_W), .N_CH(N_CH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .wr_en_i   (wr_en_i),
  .count_o   (count_o),
  .mat_o     (mat_o),
  .cyc_len_i (cyc_len),
  .match_i   (match),
  .mode_i    (mode)
);

// File: tb/tb_pwm_timer.sv
`timescale 1ns/1ps
module tb_pwm_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [2:0]  mat_o;
  logic [15:0] count_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference model state
  int m_cnt = 0, m_len = 16'hFFFF, m_mode = 0, m_sw = 0;
  int m_match[3] = '{0, 0, 0};
  int m_pwm[3]   = '{0, 0, 0};

  always #2.5 clk_i = ~clk_i;

  pwm_timer dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .mat_o(mat_o), .count_o(count_o)
  );

  function automatic logic [2:0] exp_pins();
    logic [2:0] p;
    for (int k = 0; k < 3; k++)
      p[k] = m_mode[k] ? (m_pwm[k] != 0) : m_sw[k];
    return p;
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (count_o !== 16'(m_cnt) || mat_o !== exp_pins()) begin
      errors++;
      $display("FAIL %s: count=%0d mat=%b expected count=%0d mat=%b",
               tag, count_o, mat_o, m_cnt, exp_pins());
    end
  endtask

  task automatic model_edge(input bit tk, input bit we, input int a, input int d);
    if (tk) begin
      int n;
      n = (m_cnt == m_len) ? 0 : ((m_cnt + 1) & 16'hFFFF);
      for (int k = 0; k < 3; k++) begin
        if (n == 0)               m_pwm[k] = (m_match[k] == 0);
        else if (n == m_match[k]) m_pwm[k] = 1;
      end
      m_cnt = n;
    end
    if (we) begin
      case (a)
        0:       m_len = d & 16'hFFFF;
        1, 2, 3: m_match[a-1] = d & 16'hFFFF;
        4:       m_mode = d & 7;
        5:       m_sw = d & 7;
        default: ;
      endcase
    end
  endtask

  task automatic step(input string tag, input bit tk, input bit we = 0,
                      input int a = 0, input int d = 0);
    tick_i = tk; wr_en_i = we; wr_addr_i = 3'(a); wr_data_i = 32'(d);
    @(posedge clk_i);
    model_edge(tk, we, a, d);
    @(negedge clk_i);
    tick_i = 0; wr_en_i = 0;
    compare(tag);
  endtask

  task automatic run(input string tag, input int n, input int gap = 0);
    for (int i = 0; i < n; i++) begin
      step(tag, 1'b1);
      for (int g = 0; g < gap; g++) step(tag, 1'b0);
    end
  endtask

  task automatic wr(input string tag, input int a, input int d);
    step(tag, 1'b0, 1'b1, a, d);
  endtask

  initial begin
    #(200_000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: expected=finish actual=timeout");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    compare("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1 after release");

    for (int i = 0; i < 5; i++) step("R2 no tick", 1'b0);
    run("R2 count", 4);

    // software mode pins (address 5 bits 2:0)
    wr("R4 swout", 5, 5);
    run("R4 swout hold", 3);
    wr("R4 swout", 5, 2);

    // cycle length 9, ch1 match 3, ch2 match=len, ch3 match beyond length
    wr("R3 len", 0, 9);
    wr("R6 m1", 1, 3);
    wr("R8 m2", 2, 9);
    wr("R7 m3", 3, 12);
    wr("R4 mode", 4, 7);
    run("R6 R8 R5 R3", 30);
    run("R8 sparse", 22, 2);

    // R7 raise match above length while high
    wr("R7 m3 low", 3, 2);
    while (m_cnt != 5) step("R7 approach", 1'b1);
    wr("R7 m3 over", 3, 12);
    run("R7 hold then clear", 25);

    // R9 zero match
    wr("R9 m1 zero", 1, 0);
    run("R9 zero match", 25);

    // R10 upper bits of mode ignored; immediate match write
    wr("R10 mode hi bits", 4, 32'hFFFF_FFF8 | 5);
    run("R10 mode", 12);
    wr("R10 m1 now", 1, 4);
    run("R10 match", 12);

    // R11 swout write while in PWM mode
    wr("R4 mode all", 4, 7);
    wr("R11 swout hidden", 5, 3'b101);
    run("R11 pins pwm", 10);
    wr("R11 mode off", 4, 0);
    run("R11 swout shown", 4);

    // tick and write on same edge
    wr("R4 mode on", 4, 7);
    step("R10 tick+write", 1'b1, 1'b1, 2, 1);
    run("R10 after", 15);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule